// File: doc/BRIEF.md
# Indexed Display-Mode Register File

This block is the software-facing mode register set of a simple linear-framebuffer display controller. Software selects one of twelve 16-bit registers by writing an index port, then reads or writes the selected register through a data port. The data port takes full words or single bytes. A byte write is merged with the other half of the word that the register currently returns, and the result is committed as one word write.

The stored registers hold the display resolution, colour depth, an enable/flags word, a virtual line width and X/Y panning offsets. They feed the timing logic downstream. Writes have side effects. A bank write loads a read-window or write-window byte offset, scaled by the active granularity. An enable write can change the granularity and clear the bank offsets. Switching the display on clears the panning state. The stored enable word never keeps the memory-clear-suppress flag.

The block also answers capability queries, reports the video memory size, and drives a bit-banged DDC clock/data pair. A one-cycle pulse tells the timing logic to recompute after any write that affects geometry.

Top module: `vdisp_mode_regs`

## Requirements
- R1: After reset, every stored register reads 0, `rd_bank` and `wr_bank` are 0, `gran_32k`, `dac_8bit`, `mode_on` and `recalc` are 0, and `scl_out`/`sda_out` are 1 (released). The DDC index reads 0x000F.
- R2: `bus_port` selects the access:
  - 0 is the index port. A write stores the 16-bit index and a read returns it.
  - 1 is the data word.
  - 2 is the data low byte.
  - 3 is the data high byte.
  - Register indices are: ID 0x0, XRES 0x1, YRES 0x2, BPP 0x3, ENABLE 0x4, BANK 0x5, VWIDTH 0x6, VHEIGHT 0x7, XOFF 0x8, YOFF 0x9, MEM64K 0xA, DDC 0xB.
  - XRES, YRES, BPP, VWIDTH, XOFF and YOFF store written words verbatim.
- R3: While stored ENABLE bit 1 (capabilities) is set, XRES reads MAX_X (1920), YRES reads MAX_Y (1600), BPP reads MAX_BPP (32) and BANK reads 0x1000. With bit 1 clear, XRES, YRES and BPP read the stored values.
- R4: Reads of fixed and unused indices:
  - MEM64K always reads VRAM_BYTES/65536 (0x0100 by default).
  - VHEIGHT always reads 0, and BANK reads 0 outside capability mode.
  - Any index above 0xB reads 0 and writes to it have no effect.
- R5: An ID write is stored only when the value is 0xB0C0 to 0xB0C4. A write of 0xB0C5 stores the REVISION parameter. Any other value leaves ID unchanged.
- R6: A BANK write with bit 15 set loads `rd_bank`, and one with bit 14 set loads `wr_bank`. The loaded offset is value[8:0] shifted left by 16 (64 KB granularity) or by 15 (32 KB). A write with neither bit set changes nothing.
- R7: ENABLE bit 4 sets the granularity: 1 selects 32 KB (`gran_32k`=1) and 0 selects 64 KB. An ENABLE write that changes the granularity, or that has bit 0 clear, sets both bank offsets to 0.
- R8: ENABLE write side effects:
  - A write setting bit 0 while the stored bit 0 is clear also clears XOFF, YOFF and VWIDTH.
  - A write setting bit 0 while bit 0 is already set leaves them intact.
  - Bit 7 is never stored.
  - `dac_8bit` follows bit 5 and `mode_on` follows bit 0.
- R9: A DDC write with bit 7 set stores bits 7, 1 and 0, and sets `scl_out` to bit 0 and `sda_out` to bit 1. A DDC write with bit 7 clear only clears stored bit 7, and the drive outputs keep their values.
- R10: While stored DDC bit 7 is set, a DDC read returns stored bits 7, 1 and 0, with `scl_in` in bit 2 and `sda_in` in bit 3. Otherwise the read returns 0x000F.
- R11: Byte access to the data port:
  - A low-byte write commits {readback[15:8], wdata[7:0]}.
  - A high-byte write commits {wdata[7:0], readback[7:0]}.
  - The readback used is the current one, including capability values.
  - Byte reads return the selected half in bits 7:0, with zeros above.
- R12: `recalc` is high for exactly the one cycle after a data write to XRES, YRES, BPP, VWIDTH, XOFF, YOFF or ENABLE, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_port | input | 2 | 0 index, 1 data word, 2 data low byte, 3 data high byte |
| bus_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| bus_rdata | output | 16 | Combinational read data for `bus_port` |
| scl_in | input | 1 | Sensed DDC clock line |
| sda_in | input | 1 | Sensed DDC data line |
| scl_out | output | 1 | DDC clock drive (0 pulls low, 1 releases) |
| sda_out | output | 1 | DDC data drive (0 pulls low, 1 releases) |
| rd_bank | output | SEL_W+16 | Read-window byte offset |
| wr_bank | output | SEL_W+16 | Write-window byte offset |
| gran_32k | output | 1 | 1 when the bank granularity is 32 KB |
| dac_8bit | output | 1 | 1 selects the 8-bit palette DAC, 0 the 6-bit shift |
| mode_on | output | 1 | Linear display mode enabled |
| recalc | output | 1 | One-cycle timing recompute request |

## Verification
The embedded assertions check four properties on every cycle:
- A granularity change always leaves both bank offsets at zero, and in 64 KB mode the offsets keep 64 KB alignment.
- The ID register only ever holds reset zero, a legal identifier or the revision value.
- Switching the display on always leaves the panning registers clear.
- The DDC drive lines move only on a DDC write with bit 7 set, and `recalc` only follows a data-port write.

Only the directed scenarios can show the rest:
- the exact capability and size values,
- the byte-merge words, including a merge against a capability value,
- rejected ID values,
- the DDC sense bit positions,
- that a repeated enable write keeps the offsets.

// File: rtl/vdisp_pkg.sv
package vdisp_pkg;

    typedef enum logic [3:0] {
        IX_ID      = 4'h0,
        IX_XRES    = 4'h1,
        IX_YRES    = 4'h2,
        IX_BPP     = 4'h3,
        IX_ENABLE  = 4'h4,
        IX_BANK    = 4'h5,
        IX_VWIDTH  = 4'h6,
        IX_VHEIGHT = 4'h7,
        IX_XOFF    = 4'h8,
        IX_YOFF    = 4'h9,
        IX_MEM64K  = 4'hA,
        IX_DDC     = 4'hB
    } reg_ix_e;

    typedef enum logic [1:0] {
        PORT_INDEX   = 2'd0,
        PORT_DATA    = 2'd1,
        PORT_DATA_LO = 2'd2,
        PORT_DATA_HI = 2'd3
    } port_e;

    // bit positions inside the enable word
    localparam int EN_ON    = 0;
    localparam int EN_CAPS  = 1;
    localparam int EN_GRAN  = 4;
    localparam int EN_DAC8  = 5;
    localparam int EN_NOCLR = 7;

    localparam logic [3:0] IX_LAST = 4'hB;

    typedef struct packed {
        logic [15:0] id;
        logic [15:0] xres;
        logic [15:0] yres;
        logic [15:0] bpp;
        logic [15:0] enable;
        logic [15:0] vwidth;
        logic [15:0] xoff;
        logic [15:0] yoff;
    } mode_regs_t;

endpackage

// File: rtl/vdisp_readback.sv
module vdisp_readback
    import vdisp_pkg::*;
#(
    parameter int MAX_X   = 1920,
    parameter int MAX_Y   = 1600,
    parameter int MAX_BPP = 32,
    parameter int MEM64K  = 256
) (
    input  logic [15:0] index,
    input  mode_regs_t  regs,
    input  logic        ddc_en,
    input  logic [1:0]  ddc_lines,
    input  logic        scl_in,
    input  logic        sda_in,
    output logic [15:0] rb
);
    localparam logic [15:0] CAP_BANK = 16'h0010 << 8;

    logic caps;
    logic ix_ok;

    always_comb begin
        caps  = regs.enable[EN_CAPS];
        ix_ok = (index[15:4] == 12'h000) && (index[3:0] <= IX_LAST);
        rb    = 16'h0000;
        if (ix_ok) begin
            case (index[3:0])
                IX_ID:      rb = regs.id;
                IX_XRES:    rb = caps ? 16'(MAX_X) : regs.xres;
                IX_YRES:    rb = caps ? 16'(MAX_Y) : regs.yres;
                IX_BPP:     rb = caps ? 16'(MAX_BPP) : regs.bpp;
                IX_ENABLE:  rb = regs.enable;
                IX_BANK:    rb = caps ? CAP_BANK : 16'h0000;
                IX_VWIDTH:  rb = regs.vwidth;
                IX_XOFF:    rb = regs.xoff;
                IX_YOFF:    rb = regs.yoff;
                IX_MEM64K:  rb = 16'(MEM64K);
                IX_DDC:     rb = ddc_en ? {8'h00, 1'b1, 3'b000, sda_in, scl_in, ddc_lines}
                                        : 16'h000F;
                default:    rb = 16'h0000;
            endcase
        end
    end

endmodule

// File: rtl/vdisp_bank.sv
module vdisp_bank #(
    parameter int SEL_W = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bank_wr,
    input  logic               ld_rd,
    input  logic               ld_wr,
    input  logic [SEL_W-1:0]   sel,
    input  logic               en_wr,
    input  logic               en_on,
    input  logic               en_gran32,
    output logic [SEL_W+15:0]  rd_bank,
    output logic [SEL_W+15:0]  wr_bank,
    output logic               gran_32k
);
    localparam int BANK_W = SEL_W + 16;

    typedef struct packed {
        logic [BANK_W-1:0] rd;
        logic [BANK_W-1:0] wr;
        logic              g32;
    } bank_st_t;

    bank_st_t q, d;
    logic [BANK_W-1:0] offset;

    always_comb begin
        offset = BANK_W'(sel) << (q.g32 ? 15 : 16);
        d = q;
        if (bank_wr) begin
            if (ld_rd) d.rd = offset;
            if (ld_wr) d.wr = offset;
        end
        if (en_wr) begin
            d.g32 = en_gran32;
            if (!en_on || (en_gran32 != q.g32)) begin
                d.rd = '0;
                d.wr = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_bank  = q.rd;
    assign wr_bank  = q.wr;
    assign gran_32k = q.g32;

    assert_gran_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.g32 != $past(q.g32)) |-> (q.rd == '0 && q.wr == '0));

    assert_bank_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !q.g32 |-> (q.rd[15:0] == 16'h0 && q.wr[15:0] == 16'h0));

endmodule

// File: rtl/vdisp_ddc.sv
module vdisp_ddc (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ddc_wr,
    input  logic [7:0] val,
    output logic       ddc_en,
    output logic [1:0] ddc_lines,
    output logic       scl_out,
    output logic       sda_out
);
    typedef struct packed {
        logic       en;
        logic [1:0] lines;
        logic       scl;
        logic       sda;
    } ddc_st_t;

    ddc_st_t q, d;

    always_comb begin
        d = q;
        if (ddc_wr) begin
            if (val[7]) begin
                d.en    = 1'b1;
                d.lines = val[1:0];
                d.scl   = val[0];
                d.sda   = val[1];
            end else begin
                d.en = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{en: 1'b0, lines: 2'b00, scl: 1'b1, sda: 1'b1};
        else        q <= d;
    end

    assign ddc_en    = q.en;
    assign ddc_lines = q.lines;
    assign scl_out   = q.scl;
    assign sda_out   = q.sda;

    assert_ddc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(ddc_wr && val[7]) |=> ($stable(scl_out) && $stable(sda_out)));

endmodule

// File: rtl/vdisp_mode_regs.sv
module vdisp_mode_regs
    import vdisp_pkg::*;
#(
    parameter int          MAX_X      = 1920,
    parameter int          MAX_Y      = 1600,
    parameter int          MAX_BPP    = 32,
    parameter int          VRAM_BYTES = 16777216,
    parameter logic [15:0] REVISION   = 16'hB0C5,
    parameter int          SEL_W      = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_port,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_out,
    output logic              sda_out,
    output logic [SEL_W+15:0] rd_bank,
    output logic [SEL_W+15:0] wr_bank,
    output logic              gran_32k,
    output logic              dac_8bit,
    output logic              mode_on,
    output logic              recalc
);
    localparam int          MEM64K  = VRAM_BYTES / 65536;
    localparam logic [15:0] ID_BASE = 16'hB0C0;
    localparam logic [15:0] ID_TOP  = 16'hB0C4;
    localparam logic [15:0] ID_REV  = 16'hB0C5;

    typedef struct packed {
        logic [15:0] index;
        mode_regs_t  regs;
        logic        recalc;
    } top_st_t;

    top_st_t q, d;

    logic [15:0] rb;
    logic [15:0] wword;
    logic [3:0]  ix;
    logic        ix_ok;
    logic        data_wr;
    logic        regs_wr;
    logic        ddc_en;
    logic [1:0]  ddc_lines;

    vdisp_readback #(
        .MAX_X(MAX_X), .MAX_Y(MAX_Y), .MAX_BPP(MAX_BPP), .MEM64K(MEM64K)
    ) i_readback (
        .index(q.index), .regs(q.regs), .ddc_en(ddc_en), .ddc_lines(ddc_lines),
        .scl_in(scl_in), .sda_in(sda_in), .rb(rb)
    );

    always_comb begin
        ix      = q.index[3:0];
        ix_ok   = (q.index[15:4] == 12'h000) && (ix <= IX_LAST);
        data_wr = bus_wr && (bus_port != PORT_INDEX);
        regs_wr = data_wr && ix_ok;
        case (bus_port)
            PORT_DATA_LO: wword = {rb[15:8], bus_wdata[7:0]};
            PORT_DATA_HI: wword = {bus_wdata[7:0], rb[7:0]};
            default:      wword = bus_wdata;
        endcase
        case (bus_port)
            PORT_INDEX:   bus_rdata = q.index;
            PORT_DATA_LO: bus_rdata = {8'h00, rb[7:0]};
            PORT_DATA_HI: bus_rdata = {8'h00, rb[15:8]};
            default:      bus_rdata = rb;
        endcase
    end

    always_comb begin
        d = q;
        d.recalc = 1'b0;
        if (bus_wr && bus_port == PORT_INDEX) d.index = bus_wdata;
        if (regs_wr) begin
            case (ix)
                IX_ID: begin
                    if (wword >= ID_BASE && wword <= ID_TOP) d.regs.id = wword;
                    else if (wword == ID_REV)                d.regs.id = REVISION;
                end
                IX_XRES:   begin d.regs.xres   = wword; d.recalc = 1'b1; end
                IX_YRES:   begin d.regs.yres   = wword; d.recalc = 1'b1; end
                IX_BPP:    begin d.regs.bpp    = wword; d.recalc = 1'b1; end
                IX_VWIDTH: begin d.regs.vwidth = wword; d.recalc = 1'b1; end
                IX_XOFF:   begin d.regs.xoff   = wword; d.recalc = 1'b1; end
                IX_YOFF:   begin d.regs.yoff   = wword; d.recalc = 1'b1; end
                IX_ENABLE: begin
                    d.regs.enable           = wword;
                    d.regs.enable[EN_NOCLR] = 1'b0;
                    d.recalc                = 1'b1;
                    if (wword[EN_ON] && !q.regs.enable[EN_ON]) begin
                        d.regs.xoff   = 16'h0;
                        d.regs.yoff   = 16'h0;
                        d.regs.vwidth = 16'h0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    vdisp_bank #(.SEL_W(SEL_W)) i_bank (
        .clk(clk), .rst_n(rst_n),
        .bank_wr(regs_wr && ix == IX_BANK),
        .ld_rd(wword[15]), .ld_wr(wword[14]), .sel(wword[SEL_W-1:0]),
        .en_wr(regs_wr && ix == IX_ENABLE),
        .en_on(wword[EN_ON]), .en_gran32(wword[EN_GRAN]),
        .rd_bank(rd_bank), .wr_bank(wr_bank), .gran_32k(gran_32k)
    );

    vdisp_ddc i_ddc (
        .clk(clk), .rst_n(rst_n),
        .ddc_wr(regs_wr && ix == IX_DDC), .val(wword[7:0]),
        .ddc_en(ddc_en), .ddc_lines(ddc_lines),
        .scl_out(scl_out), .sda_out(sda_out)
    );

    assign dac_8bit = q.regs.enable[EN_DAC8];
    assign mode_on  = q.regs.enable[EN_ON];
    assign recalc   = q.recalc;

    assert_id_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.regs.id == 16'h0) || (q.regs.id >= ID_BASE && q.regs.id <= ID_TOP)
        || (q.regs.id == REVISION));

    assert_enable_clears_pan_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.regs.enable[EN_ON]) |->
        (q.regs.xoff == 16'h0 && q.regs.yoff == 16'h0 && q.regs.vwidth == 16'h0));

    assert_recalc_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
        q.recalc |-> $past(bus_wr && bus_port != PORT_INDEX));

endmodule

// File: tb/test_vdisp_mode_regs.sv
module test_vdisp_mode_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_port = 2'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        scl_in = 1'b1;
    logic        sda_in = 1'b1;
    logic        scl_out, sda_out;
    logic [24:0] rd_bank, wr_bank;
    logic        gran_32k, dac_8bit, mode_on, recalc;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    vdisp_mode_regs i_vdisp_mode_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_port(bus_port),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .scl_in(scl_in), .sda_in(sda_in),
        .scl_out(scl_out), .sda_out(sda_out), .rd_bank(rd_bank), .wr_bank(wr_bank),
        .gran_32k(gran_32k), .dac_8bit(dac_8bit), .mode_on(mode_on), .recalc(recalc)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_wr = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] p, input logic [15:0] v);
        @(negedge clk);
        bus_port = p; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] p, output logic [15:0] v);
        @(negedge clk);
        bus_port = p;
        #1 v = bus_rdata;
    endtask

    task automatic wr_reg(input logic [15:0] ix, input logic [15:0] v);
        wr(2'd0, ix);
        wr(2'd1, v);
    endtask

    task automatic rd_reg(input logic [15:0] ix, output logic [15:0] v);
        wr(2'd0, ix);
        rd(2'd1, v);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        do_reset();
        for (int i = 0; i < 10; i++) begin
            rd_reg(16'(i), v);
            chk("R1 reg zero", v, 16'h0);
        end
        rd_reg(16'hB, v);   chk("R1 ddc idle read", v, 16'h000F);
        chk("R1 banks", {rd_bank, wr_bank}, 0);
        chk("R1 flags", {gran_32k, dac_8bit, mode_on, recalc}, 0);
        chk("R1 ddc drive released", {scl_out, sda_out}, 2'b11);
    endtask

    task automatic t_index();
        logic [15:0] v;
        do_reset();
        wr(2'd0, 16'h1234); rd(2'd0, v);  chk("R2 index readback", v, 16'h1234);
        wr_reg(16'h1, 16'd640); wr_reg(16'h2, 16'd480); wr_reg(16'h3, 16'd16);
        wr_reg(16'h6, 16'd800); wr_reg(16'h8, 16'd12); wr_reg(16'h9, 16'd34);
        rd_reg(16'h1, v); chk("R2 xres", v, 16'd640);
        rd_reg(16'h2, v); chk("R2 yres", v, 16'd480);
        rd_reg(16'h3, v); chk("R2 bpp", v, 16'd16);
        rd_reg(16'h6, v); chk("R2 vwidth", v, 16'd800);
        rd_reg(16'h8, v); chk("R2 xoff", v, 16'd12);
        rd_reg(16'h9, v); chk("R2 yoff", v, 16'd34);
    endtask

    task automatic t_caps();
        logic [15:0] v;
        do_reset();
        wr_reg(16'h1, 16'd640);
        wr_reg(16'h4, 16'h0002);
        rd_reg(16'h1, v); chk("R3 caps xres", v, 16'd1920);
        rd_reg(16'h2, v); chk("R3 caps yres", v, 16'd1600);
        rd_reg(16'h3, v); chk("R3 caps bpp", v, 16'd32);
        rd_reg(16'h5, v); chk("R3 caps bank", v, 16'h1000);
        wr_reg(16'h4, 16'h0000);
        rd_reg(16'h1, v); chk("R3 stored xres after caps", v, 16'd640);
    endtask

    task automatic t_misc();
        logic [15:0] v;
        do_reset();
        rd_reg(16'hA, v); chk("R4 mem64k", v, 16'h0100);
        wr_reg(16'h7, 16'h0300); rd_reg(16'h7, v); chk("R4 vheight reads 0", v, 16'h0);
        wr_reg(16'h5, 16'hC001); rd_reg(16'h5, v); chk("R4 bank reads 0", v, 16'h0);
        wr_reg(16'hC, 16'h0055); rd_reg(16'hC, v); chk("R4 index 0xC reads 0", v, 16'h0);
        wr_reg(16'h0101, 16'h0077); rd_reg(16'h0101, v); chk("R4 index 0x101 reads 0", v, 16'h0);
        rd_reg(16'h1, v); chk("R4 alias write ignored", v, 16'h0);
    endtask

    task automatic t_id();
        logic [15:0] v;
        do_reset();
        wr_reg(16'h0, 16'hB0C2); rd_reg(16'h0, v); chk("R5 id legal", v, 16'hB0C2);
        wr_reg(16'h0, 16'hB0C6); rd_reg(16'h0, v); chk("R5 id rejected high", v, 16'hB0C2);
        wr_reg(16'h0, 16'h1234); rd_reg(16'h0, v); chk("R5 id rejected other", v, 16'hB0C2);
        wr_reg(16'h0, 16'hB0C5); rd_reg(16'h0, v); chk("R5 id revision", v, 16'hB0C5);
        wr_reg(16'h0, 16'hB0C0); rd_reg(16'h0, v); chk("R5 id low edge", v, 16'hB0C0);
    endtask

    task automatic t_bank();
        do_reset();
        wr_reg(16'h5, 16'h8005);
        chk("R6 read bank 64K", rd_bank, 25'h0050000);
        chk("R6 write bank untouched", wr_bank, 25'h0);
        wr_reg(16'h5, 16'h41FF);
        chk("R6 write bank max", wr_bank, 25'h1FF0000);
        chk("R6 read bank kept", rd_bank, 25'h0050000);
        wr_reg(16'h5, 16'h0003);
        chk("R6 no select bits", {rd_bank, wr_bank}, {25'h0050000, 25'h1FF0000});
    endtask

    task automatic t_gran();
        do_reset();
        wr_reg(16'h4, 16'h0001);
        wr_reg(16'h5, 16'hC002);
        chk("R7 banks 64K", {rd_bank, wr_bank}, {25'h20000, 25'h20000});
        wr_reg(16'h4, 16'h0011);
        chk("R7 gran 32K flag", gran_32k, 1);
        chk("R7 gran change flush", {rd_bank, wr_bank}, 0);
        wr_reg(16'h5, 16'h8003);
        chk("R6 read bank 32K", rd_bank, 25'h18000);
        wr_reg(16'h4, 16'h0011);
        chk("R7 same gran keeps bank", rd_bank, 25'h18000);
        wr_reg(16'h4, 16'h0010);
        chk("R7 disable flush", {rd_bank, wr_bank, mode_on}, 0);
    endtask

    task automatic t_enable();
        logic [15:0] v;
        do_reset();
        wr_reg(16'h8, 16'd5); wr_reg(16'h9, 16'd6); wr_reg(16'h6, 16'd10);
        wr_reg(16'h4, 16'h00A1);
        rd_reg(16'h4, v); chk("R8 noclear not stored", v, 16'h0021);
        chk("R8 dac and on", {dac_8bit, mode_on}, 2'b11);
        rd_reg(16'h8, v); chk("R8 xoff cleared", v, 16'h0);
        rd_reg(16'h9, v); chk("R8 yoff cleared", v, 16'h0);
        rd_reg(16'h6, v); chk("R8 vwidth cleared", v, 16'h0);
        wr_reg(16'h8, 16'd7);
        wr_reg(16'h4, 16'h0001);
        rd_reg(16'h8, v); chk("R8 re-enable keeps xoff", v, 16'd7);
        chk("R8 dac 6-bit", dac_8bit, 0);
    endtask

    task automatic t_ddc();
        logic [15:0] v;
        do_reset();
        wr_reg(16'hB, 16'h0083);
        chk("R9 drive released", {scl_out, sda_out}, 2'b11);
        wr_reg(16'hB, 16'h0080);
        chk("R9 drive low", {scl_out, sda_out}, 2'b00);
        scl_in = 1'b1; sda_in = 1'b0;
        rd_reg(16'hB, v); chk("R10 sense scl", v, 16'h0084);
        wr_reg(16'hB, 16'h0002);
        chk("R9 bit7 clear keeps drive", {scl_out, sda_out}, 2'b00);
        rd_reg(16'hB, v); chk("R10 idle read", v, 16'h000F);
        wr_reg(16'hB, 16'h0081);
        chk("R9 scl only", {scl_out, sda_out}, 2'b10);
        scl_in = 1'b0; sda_in = 1'b1;
        rd_reg(16'hB, v); chk("R10 sense sda", v, 16'h0089);
        scl_in = 1'b1; sda_in = 1'b1;
    endtask

    task automatic t_bytes();
        logic [15:0] v;
        do_reset();
        wr_reg(16'h1, 16'h1234);
        wr(2'd2, 16'hFF56); rd(2'd1, v); chk("R11 low byte merge", v, 16'h1256);
        wr(2'd3, 16'h00AB); rd(2'd1, v); chk("R11 high byte merge", v, 16'hAB56);
        rd(2'd2, v); chk("R11 low byte read", v, 16'h0056);
        rd(2'd3, v); chk("R11 high byte read", v, 16'h00AB);
        wr_reg(16'h4, 16'h0002);
        wr_reg(16'h3, 16'h0000);
        wr(2'd0, 16'h3);
        wr(2'd3, 16'h0001);
        wr_reg(16'h4, 16'h0000);
        rd_reg(16'h3, v); chk("R11 merge with caps value", v, 16'h0120);
    endtask

    task automatic t_recalc();
        do_reset();
        wr_reg(16'h1, 16'd320);
        chk("R12 recalc after xres", recalc, 1);
        @(negedge clk);
        chk("R12 recalc one cycle", recalc, 0);
        wr_reg(16'h7, 16'd200);
        chk("R12 no recalc vheight", recalc, 0);
        wr_reg(16'h5, 16'h8001);
        chk("R12 no recalc bank", recalc, 0);
        wr_reg(16'h4, 16'h0000);
        chk("R12 recalc after enable", recalc, 1);
        wr(2'd0, 16'h1);
        chk("R12 no recalc index", recalc, 0);
    endtask

    initial begin
        t_reset();
        t_index();
        t_caps();
        t_misc();
        t_id();
        t_bank();
        t_gran();
        t_enable();
        t_ddc();
        t_bytes();
        t_recalc();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule